// File: doc/BRIEF.md
# Virtual-to-Physical Address Translation Unit

This unit sits between a CPU load/store port and memory. It turns a virtual address into a physical one. Address bits 11:0 are the in-page offset and pass through unchanged. The bits above them form the virtual page number (VPN), which selects a page-table entry. A small fully associative lookaside store holds recently used entries and is searched on every request. On a hit the answer comes back in the same cycle. On a miss the unit holds the CPU, reads the entry from an in-memory page table at a base register plus the scaled VPN, installs it, and then answers as a hit.

Every access is checked against the entry. A clear presence bit returns a page fault and nothing is installed. An owner process ID that differs from the current process ID returns an access violation. So does a read or write that the entry's rights do not allow. A permitted write to a clean page sets the cached copy's dirty bit. A flush input drops every cached translation at once.

Top module: `addr_xlate_unit`

## Requirements
- R1: A request whose VPN is cached and passes the checks gets `rsp_valid_o` in the same cycle. `rsp_paddr_o` is the cached physical page number above the unchanged offset, and no table read is issued.
- R2: A request whose VPN is not cached gets no response in its first cycle. From the next cycle `mem_req_o` is high with `mem_addr_o = pt_base_i + VPN*4`, and both hold until the cycle in which `mem_ack_i` is high.
- R3: The table entry word `mem_rdata_i` is decoded as follows: bits 31:12 physical page number, bits 11:4 owner process ID, bit 3 dirty, bit 2 write allowed, bit 1 read allowed, bit 0 present.
- R4: When the acknowledged entry has present=1, it is installed and the held request is answered as a hit in the cycle after the acknowledge.
- R5: When the acknowledged entry has present=0, the response comes in the acknowledge cycle with `rsp_pfault_o`=1 and `rsp_paddr_o`=0. Nothing is installed, so the same page misses again.
- R6: A hit whose owner ID differs from `cur_pid_i` responds with `rsp_perm_o`=1 and `rsp_paddr_o`=0.
- R7: A hit that reads without read permission, or writes without write permission, responds with `rsp_perm_o`=1 and `rsp_paddr_o`=0. A faulting write leaves the dirty bit unchanged.
- R8: On every hit, `rsp_dirty_o` shows the cached dirty bit as it stood before this access. A permitted write sets that bit.
- R9: A cycle with `flush_i`=1 invalidates all entries, so each page misses on its next access.
- R10: An install uses the lowest-numbered invalid entry. When all entries are valid, the victim is taken round-robin, starting at entry 0 and advancing by one with each eviction.
- R11: After reset all entries are invalid, and `rsp_valid_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | CPU request present, held until the response |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| cur_pid_i | input | 8 | Current process ID |
| pt_base_i | input | 32 | Page-table base address |
| flush_i | input | 1 | Invalidate all cached translations |
| rsp_valid_o | output | 1 | Response this cycle |
| rsp_paddr_o | output | 32 | Physical address, 0 on any fault |
| rsp_pfault_o | output | 1 | Page not present |
| rsp_perm_o | output | 1 | Owner or access-type violation |
| rsp_dirty_o | output | 1 | Cached dirty bit before this access |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 32 | Table entry address |
| mem_ack_i | input | 1 | Table read data valid |
| mem_rdata_i | input | 32 | Table entry word |

## Verification
The bench fills all entries and keeps forcing evictions. A victim chooser that reused a slot or started at the wrong entry would turn expected hits into table reads, or expected misses into hits. A non-present entry is accessed twice. Installing it by mistake would make the second access hit with a stale page. Writes to clean pages are repeated, so a dirty bit that never sets, or that a faulting write sets, shows on `rsp_dirty_o`. Accesses after a flush and after a change of table base catch stale entries and a wrong entry address.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = 20;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int PID_W = 8;

  // table entry word layout, MSB first
  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [PID_W-1:0] pid;
    logic             dirty;
    logic             wr_ok;
    logic             rd_ok;
    logic             present;
  } pte_t;

  localparam int PTE_W = $bits(pte_t);
endpackage

// File: rtl/xlate_store.sv
module xlate_store
  import xlate_pkg::*;
#(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] look_vpn_i,
  output logic [N-1:0]     hit_vec_o,
  output logic             hit_o,
  output pte_t             hit_pte_o,
  input  logic             flush_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  pte_t             fill_pte_i,
  input  logic             set_dirty_i,
  output logic [N-1:0]     valid_o
);
  logic [N-1:0]     valid_q;
  logic [VPN_W-1:0] vpn_q [N];
  pte_t             ent_q [N];

  for (genvar i = 0; i < N; i++) begin : g_match
    assign hit_vec_o[i] = valid_q[i] && ent_q[i].present && (vpn_q[i] == look_vpn_i);
  end

  assign hit_o   = |hit_vec_o;
  assign valid_o = valid_q;

  always_comb begin
    hit_pte_o = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec_o[i]) hit_pte_o = pte_t'(hit_pte_o | ent_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (flush_i) valid_q <= '0;
    else if (fill_i) valid_q[fill_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < N; i++) begin
      if (fill_i && !flush_i && (fill_idx_i == IDX_W'(i))) begin
        vpn_q[i] <= fill_vpn_i;
        ent_q[i] <= fill_pte_i;
      end else if (set_dirty_i && hit_vec_o[i]) begin
        ent_q[i].dirty <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             advance_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] rr_q;
  logic             all_valid;

  assign all_valid = &valid_i;

  always_comb begin
    victim_o = rr_q;
    for (int i = N - 1; i >= 0; i--)
      if (!valid_i[i]) victim_o = IDX_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (advance_i && all_valid)
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
  import xlate_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int PTE_SHIFT = 2,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  input  logic [PID_W-1:0] cur_pid_i,
  input  logic [PA_W-1:0]  pt_base_i,
  input  logic             flush_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_pfault_o,
  output logic             rsp_perm_o,
  output logic             rsp_dirty_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  typedef enum logic {S_IDLE, S_WALK} state_e;

  state_e           state_q;
  logic [VPN_W-1:0] walk_vpn_q;
  logic [VPN_W-1:0] req_vpn;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic             hit;
  pte_t             hit_pte;
  pte_t             fetched;
  logic [IDX_W-1:0] victim;
  logic             hit_rsp, perm_bad, walk_done, fill, set_dirty;

  assign req_vpn = req_vaddr_i[VA_W-1:OFF_W];
  assign fetched = pte_t'(mem_rdata_i);

  xlate_store #(.N(ENTRIES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .look_vpn_i  (req_vpn),
    .hit_vec_o   (hit_vec),
    .hit_o       (hit),
    .hit_pte_o   (hit_pte),
    .flush_i     (flush_i),
    .fill_i      (fill),
    .fill_idx_i  (victim),
    .fill_vpn_i  (walk_vpn_q),
    .fill_pte_i  (fetched),
    .set_dirty_i (set_dirty),
    .valid_o     (valid_vec)
  );

  xlate_victim #(.N(ENTRIES)) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_vec),
    .advance_i (fill),
    .victim_o  (victim)
  );

  assign perm_bad  = (hit_pte.pid != cur_pid_i) ||
                     (req_write_i ? !hit_pte.wr_ok : !hit_pte.rd_ok);
  assign hit_rsp   = (state_q == S_IDLE) && req_valid_i && hit;
  assign walk_done = (state_q == S_WALK) && mem_ack_i;
  assign fill      = walk_done && fetched.present && !flush_i;
  assign set_dirty = hit_rsp && !perm_bad && req_write_i && !hit_pte.dirty;

  assign rsp_pfault_o = walk_done && !fetched.present;
  assign rsp_perm_o   = hit_rsp && perm_bad;
  assign rsp_valid_o  = hit_rsp || rsp_pfault_o;
  assign rsp_dirty_o  = hit_rsp && hit_pte.dirty;
  assign rsp_paddr_o  = (hit_rsp && !perm_bad) ?
                        {hit_pte.ppn, req_vaddr_i[OFF_W-1:0]} : '0;

  assign mem_req_o  = (state_q == S_WALK);
  assign mem_addr_o = pt_base_i + ({{(PA_W-VPN_W){1'b0}}, walk_vpn_q} << PTE_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      walk_vpn_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i && !hit) begin
          state_q    <= S_WALK;
          walk_vpn_q <= req_vpn;
        end
        S_WALK: if (mem_ack_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
  parameter int N = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          flush_i,
  input logic          mem_req_i,
  input logic          mem_ack_i,
  input logic [31:0]   mem_addr_i,
  input logic          rsp_valid_i,
  input logic          rsp_pfault_i,
  input logic          rsp_perm_i,
  input logic [N-1:0]  hit_vec_i
);
  // R10: installs never duplicate a page
  assert_single_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_i));

  assert_walk_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_ack_i |=> mem_req_i);

  assert_walk_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_ack_i |=> $stable(mem_addr_i));

  assert_pfault_on_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_pfault_i |-> mem_ack_i && mem_req_i && !rsp_perm_i);

  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !(rsp_valid_i && !rsp_pfault_i));

  assert_rsp_needs_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |-> req_valid_i);
endmodule

bind addr_xlate_unit xlate_chk #(.N(ENTRIES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .flush_i      (flush_i),
  .mem_req_i    (mem_req_o),
  .mem_ack_i    (mem_ack_i),
  .mem_addr_i   (mem_addr_o),
  .rsp_valid_i  (rsp_valid_o),
  .rsp_pfault_i (rsp_pfault_o),
  .rsp_perm_i   (rsp_perm_o),
  .hit_vec_i    (hit_vec)
);

// File: tb/addr_xlate_unit_tb.sv
module addr_xlate_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  cur_pid = 8'h05;
  logic [31:0] pt_base = 32'h0010_0000;
  logic        flush = 1'b0;
  logic        rsp_valid, rsp_pfault, rsp_perm, rsp_dirty, mem_req;
  logic [31:0] rsp_paddr, mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  // reference model
  bit        m_valid [8];
  bit [19:0] m_vpn   [8];
  bit [31:0] m_pte   [8];
  int        m_rr = 0;
  bit [31:0] pt_mem [bit [19:0]];

  always #2 clk = ~clk;

  addr_xlate_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .cur_pid_i(cur_pid), .pt_base_i(pt_base), .flush_i(flush),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_pfault_o(rsp_pfault),
    .rsp_perm_o(rsp_perm), .rsp_dirty_o(rsp_dirty), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic bit [31:0] mk_pte(bit [19:0] ppn, bit [7:0] pid, bit d, bit w, bit r, bit p);
    return {ppn, pid, d, w, r, p};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int m_find(bit [19:0] vpn);
    for (int i = 0; i < 8; i++) if (m_valid[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int m_install(bit [19:0] vpn, bit [31:0] pte);
    int slot = -1;
    for (int i = 7; i >= 0; i--) if (!m_valid[i]) slot = i;
    if (slot < 0) begin
      slot = m_rr;
      m_rr = (m_rr + 1) % 8;
    end
    m_valid[slot] = 1'b1;
    m_vpn[slot]   = vpn;
    m_pte[slot]   = pte;
    return slot;
  endfunction

  task automatic access(bit [31:0] va, bit wr, int lat, string req);
    bit [19:0] vpn = va[31:12];
    int idx;
    bit [31:0] e;
    bit bad;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    idx = m_find(vpn);
    if (idx < 0) begin
      #1;
      chk(req, "miss no rsp", rsp_valid, 0);
      chk(req, "miss no req yet", mem_req, 0);
      for (int c = 0; c <= lat; c++) begin
        @(negedge clk);
        if (c == lat) begin
          mem_ack = 1'b1;
          mem_rdata = pt_mem.exists(vpn) ? pt_mem[vpn] : 32'h0;
        end
        #1;
        chk(req, "walk req", mem_req, 1);
        chk(req, "walk addr", mem_addr, pt_base + {10'b0, vpn, 2'b00});
        if (c == lat && !mem_rdata[0]) begin
          chk(req, "pfault valid", rsp_valid, 1);
          chk(req, "pfault flag", rsp_pfault, 1);
          chk(req, "pfault paddr", rsp_paddr, 0);
          @(negedge clk);
          mem_ack = 1'b0; req_valid = 1'b0;
          return;
        end
        chk(req, "walk no rsp", rsp_valid, 0);
        if (c == lat) idx = m_install(vpn, mem_rdata);
      end
      @(negedge clk);
      mem_ack = 1'b0;
    end
    #1;
    e = m_pte[idx];
    bad = (e[11:4] != cur_pid) || (wr ? !e[2] : !e[1]);
    chk(req, "hit valid", rsp_valid, 1);
    chk(req, "hit no walk", mem_req, 0);
    chk(req, "hit perm", rsp_perm, bad);
    chk(req, "hit pfault", rsp_pfault, 0);
    chk(req, "hit dirty", rsp_dirty, e[3]);
    chk(req, "hit paddr", rsp_paddr, bad ? 32'h0 : {e[31:12], va[11:0]});
    if (wr && !bad) m_pte[idx][3] = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < 8; i++) m_valid[i] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    pt_mem[20'h00001] = mk_pte(20'hA0001, 8'h05, 0, 1, 1, 1);
    pt_mem[20'h00002] = mk_pte(20'hA0002, 8'h05, 0, 0, 1, 1);
    pt_mem[20'h00003] = mk_pte(20'hA0003, 8'h05, 0, 1, 1, 0);
    pt_mem[20'h00004] = mk_pte(20'hA0004, 8'h07, 1, 1, 1, 1);
    for (int i = 0; i < 8; i++) pt_mem[20'h00010 + 20'(i)] = mk_pte(20'hB0000 + 20'(i), 8'h07, 0, 1, 0, 1);

    repeat (3) @(negedge clk);
    #1;
    chk("R11", "reset rsp", rsp_valid, 0);
    chk("R11", "reset req", mem_req, 0);
    rst_n = 1'b1;

    access(32'h0000_1234, 0, 2, "R4");
    access(32'h0000_1FFC, 0, 0, "R1");
    access(32'h0000_1010, 1, 0, "R8");
    access(32'h0000_1014, 1, 0, "R8");
    access(32'h0000_1018, 0, 0, "R8");
    access(32'h0000_2040, 0, 1, "R3");
    access(32'h0000_2044, 1, 0, "R7");
    access(32'h0000_2048, 0, 0, "R7");
    access(32'h0000_3000, 0, 1, "R5");
    access(32'h0000_3004, 0, 3, "R5");
    access(32'h0000_4ABC, 0, 0, "R6");
    cur_pid = 8'h07;
    access(32'h0000_4ABC, 1, 0, "R6");
    access(32'h0000_1010, 0, 0, "R6");

    pt_base = 32'h0020_0000;
    do_flush();
    access(32'h0000_4008, 0, 1, "R9");
    access(32'h0000_4008, 0, 0, "R9");
    for (int i = 0; i < 7; i++) access(32'h0001_0000 + 32'(i) * 32'h1000, 0, i % 3, "R10");
    access(32'h0001_7000, 0, 0, "R10");
    access(32'h0001_0100, 0, 0, "R10");
    access(32'h0000_4000, 0, 2, "R10");
    access(32'h0001_1000, 0, 0, "R10");
    access(32'h0001_0200, 1, 1, "R2");
    access(32'h0001_0204, 1, 0, "R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule